// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block turns a fan's tach pulse train into an 8-bit speed reading. It counts ticks of a slow reference clock across two complete tach periods. A small number therefore means a fast fan, and a stalled or very slow fan reads 0xFF. The reference clock is the incoming base-rate tick divided by 1, 2, 4 or 8. A 2-bit range select chooses the divisor, so that the count can be fitted to the fan's expected speed. At an 11.25 kHz base rate the reading is 11250·60 / (RPM·N).

A measurement cycle starts only when monitoring is enabled and the PWM drive is high. Once a cycle starts, the PWM level has no further effect. The tach input is synchronised inside the block, and only its rising edges matter. The first edge after the start is discarded. The window opens on the second edge and closes on the fourth. When the window closes, the result is written to the reading register, and a one-cycle done strobe is raised in the same cycle. Cycles repeat back to back for as long as monitoring stays on.

Top module: `fan_tach_counter`

## Requirements
- R1: After reset, `speed_rd` is 0 and `meas_done` is 0.
- R2: A measurement cycle starts only in a clock cycle where `mon_en` and `pwm_hi` are both 1. While the block is idle, holding `pwm_hi` low gives no `meas_done`.
- R3: `tach_in` passes through two synchronising flops. After the start, the first rising edge is ignored. The reading is the number of gate ticks in the cycles after the second rising edge, up to and including the cycle of the fourth. Example: with N=1, a base tick every 4 clocks and a 40-clock tach period, the reading is 20.
- R4: The `range_sel` codes are 2'b00 for N=1, 2'b01 for N=2, 2'b10 for N=4 and 2'b11 for N=8. A gate tick is every N-th `base_tick`, counted from the start of the cycle.
- R5: When the count reaches 255, the cycle ends at once with a reading of 0xFF. This applies in every phase, including while the block waits for the first or second edge, so a stalled fan reads 0xFF.
- R6: If `pwm_hi` falls after a cycle has started, that cycle continues unchanged.
- R7: `range_sel` is captured when a cycle starts. A change during the cycle does not alter that cycle's reading.
- R8: `meas_done` is high for exactly one clock, in the same cycle that `speed_rd` takes its new value. At all other times `speed_rd` holds its value.
- R9: After `meas_done`, a new cycle starts at the next clock if the start condition holds. Clearing `mon_en` abandons the current cycle, with no `meas_done` and no change to `speed_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-clock pulse at the base measurement rate |
| range_sel | input | 2 | Speed-range select (divisor N) |
| mon_en | input | 1 | Monitoring enable |
| pwm_hi | input | 1 | PWM drive level, 1 = high |
| tach_in | input | 1 | Raw tach input |
| speed_rd | output | 8 | Latest speed reading |
| meas_done | output | 1 | One-clock strobe when a reading is written |

## Verification
The closing fourth tach edge and the counter reaching 255 can land in the same clock. When that happens, saturation must win, and a gate tick in the closing cycle must still be counted. The bench provokes this by sweeping the tach period in small steps across the point where two periods hold about 255 gate ticks. A stalled fan and an over-slow fan are also applied, so that saturation is seen both before and after the window opens. In every case, a behavioural reference model judges the outcome by comparing reading and strobe on every clock.

// File: rtl/fan_tach_counter.sv
module fan_tach_counter #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic [1:0]       range_sel,
  input  logic             mon_en,
  input  logic             pwm_hi,
  input  logic             tach_in,
  output logic [CNT_W-1:0] speed_rd,
  output logic             meas_done
);

  localparam logic [CNT_W:0] FULL = (CNT_W+1)'((1 << CNT_W) - 1);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SKIP  = 3'd1,
    ST_ARM   = 3'd2,
    ST_OPEN  = 3'd3,
    ST_CLOSE = 3'd4
  } phase_t;

  phase_t               st;
  logic [SYNC_STAGES:0] sh;
  logic [1:0]           rng;
  logic [DIV_W-1:0]     div, mask;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W:0]       nxt;
  logic                 rise, gate_tk, sat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], tach_in};

  assign rise    = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign mask    = DIV_W'((1 << rng) - 1);
  assign gate_tk = base_tick && ((div & mask) == mask) && (st != ST_IDLE);
  assign nxt     = {1'b0, cnt} + (CNT_W+1)'(gate_tk);
  assign sat     = nxt >= FULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rng       <= '0;
      div       <= '0;
      cnt       <= '0;
      speed_rd  <= '0;
      meas_done <= 1'b0;
    end else begin
      meas_done <= 1'b0;
      if (st == ST_IDLE) begin
        if (mon_en && pwm_hi) begin
          st  <= ST_SKIP;
          rng <= range_sel;
          div <= '0;
          cnt <= '0;
        end
      end else if (!mon_en) begin
        st <= ST_IDLE;
      end else begin
        if (base_tick) div <= div + 1'b1;
        if (sat) begin
          speed_rd  <= FULL[CNT_W-1:0];
          meas_done <= 1'b1;
          st        <= ST_IDLE;
        end else begin
          unique case (st)
            ST_SKIP: begin
              cnt <= nxt[CNT_W-1:0];
              if (rise) st <= ST_ARM;
            end
            ST_ARM: begin
              if (rise) begin
                cnt <= '0;
                st  <= ST_OPEN;
              end else cnt <= nxt[CNT_W-1:0];
            end
            ST_OPEN: begin
              cnt <= nxt[CNT_W-1:0];
              if (rise) st <= ST_CLOSE;
            end
            ST_CLOSE: begin
              if (rise) begin
                speed_rd  <= nxt[CNT_W-1:0];
                meas_done <= 1'b1;
                st        <= ST_IDLE;
              end else cnt <= nxt[CNT_W-1:0];
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

endmodule

module fan_tach_counter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mon_en,
  input logic             pwm_hi,
  input logic             meas_done,
  input logic [CNT_W-1:0] speed_rd,
  input logic [2:0]       st,
  input logic [1:0]       rng
);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && !(mon_en && pwm_hi)) |=> st == 3'd0);

  assert_first_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd0 |=> (st == 3'd0 || st == 3'd1));

  assert_pwm_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd0 && mon_en && !pwm_hi) |=> (st != 3'd0 || meas_done));

  assert_range_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd0 && $past(st) != 3'd0) |-> $stable(rng));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> !meas_done);

  assert_reading_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |-> $stable(speed_rd));

  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mon_en) |-> !meas_done);

endmodule

bind fan_tach_counter fan_tach_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .pwm_hi(pwm_hi),
  .meas_done(meas_done), .speed_rd(speed_rd), .st(st), .rng(rng)
);

// File: tb/fan_tach_counter_tb_top.sv
`timescale 1ns/1ps
module fan_tach_counter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic [1:0] range_sel = 2'b00;
  logic       mon_en = 1'b0;
  logic       pwm_hi = 1'b0;
  logic       tach_in = 1'b0;
  logic [7:0] speed_rd;
  logic       meas_done;

  always #2.5 clk = ~clk;

  fan_tach_counter dut_i (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .range_sel(range_sel),
    .mon_en(mon_en), .pwm_hi(pwm_hi), .tach_in(tach_in),
    .speed_rd(speed_rd), .meas_done(meas_done)
  );

  int    n_vec = 0, n_bad = 0, cyc = 0, dones = 0;
  int    tach_per = 40, tph = 0, btc = 0;
  string req = "R1";

  // stimulus generators
  always @(negedge clk) begin
    btc = (btc + 1) % 4;
    base_tick = (btc == 0);
    if (tach_per == 0) tach_in = 1'b0;
    else begin
      tph = (tph + 1) % tach_per;
      tach_in = (tph < tach_per / 2);
    end
  end

  // behavioural reference model
  int m_phase = 0, m_n = 1, m_div = 0, m_cnt = 0, m_rd = 0;
  bit m_done = 0, m_q1 = 0, m_q2 = 0, m_q3 = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_n = 1; m_div = 0; m_cnt = 0; m_rd = 0;
      m_done = 0; m_q1 = 0; m_q2 = 0; m_q3 = 0;
    end else begin
      bit edge_seen, g;
      int s;
      edge_seen = m_q2 && !m_q3;
      m_q3 = m_q2; m_q2 = m_q1; m_q1 = tach_in;
      m_done = 0;
      g = base_tick && (m_div % m_n == m_n - 1);
      if (m_phase == 0) begin
        if (mon_en && pwm_hi) begin
          m_phase = 1; m_n = 1 << range_sel; m_div = 0; m_cnt = 0;
        end
      end else if (!mon_en) m_phase = 0;
      else begin
        if (base_tick) m_div++;
        s = m_cnt + int'(g);
        if (s >= 255) begin
          m_rd = 255; m_done = 1; m_phase = 0;
        end else if (m_phase == 2 && edge_seen) begin
          m_cnt = 0; m_phase = 3;
        end else if (m_phase == 4 && edge_seen) begin
          m_rd = s; m_done = 1; m_phase = 0;
        end else begin
          m_cnt = s;
          if (edge_seen) m_phase++;
        end
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      n_vec++;
      if (speed_rd !== 8'(m_rd) || meas_done !== m_done) begin
        n_bad++;
        $display("FAIL %s cycle %0d: rd=%0d done=%0b expected rd=%0d done=%0b",
                 req, cyc, speed_rd, meas_done, m_rd, m_done);
      end
      if (meas_done) dones++;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wait_done(input int maxc, output int v);
    v = -1;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      #0.5;
      if (meas_done) begin v = speed_rd; break; end
    end
  endtask

  task automatic idle_off();
    mon_en = 0; pwm_hi = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int v, d0, r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    chk(speed_rd == 0, "R1", speed_rd, 0);
    chk(meas_done == 0, "R1", meas_done, 0);

    req = "R2"; d0 = dones;
    mon_en = 1; pwm_hi = 0;
    repeat (400) @(negedge clk);
    chk(dones == d0, "R2", dones - d0, 0);

    req = "R3"; pwm_hi = 1; tach_per = 40;
    wait_done(600, v); wait_done(600, v);
    chk(v == 20, "R3", v, 20);
    req = "R9"; d0 = dones;
    wait_done(600, v); wait_done(600, v);
    chk(dones - d0 == 2, "R9", dones - d0, 2);

    req = "R4";
    for (int k = 0; k < 4; k++) begin
      idle_off();
      range_sel = 2'(k); mon_en = 1; pwm_hi = 1;
      wait_done(2000, v);
      if (k < 3) chk(v == 20 >> k, "R4", v, 20 >> k);
      else chk(v == 2 || v == 3, "R4", v, 2);
    end

    req = "R6"; idle_off(); range_sel = 0;
    mon_en = 1; pwm_hi = 1;
    repeat (3) @(negedge clk);
    pwm_hi = 0;
    wait_done(600, v);
    chk(v == 20, "R6", v, 20);

    req = "R7"; idle_off(); range_sel = 0;
    mon_en = 1; pwm_hi = 1;
    repeat (10) @(negedge clk);
    range_sel = 2'b11;
    wait_done(600, v);
    chk(v == 20, "R7", v, 20);

    req = "R5"; idle_off(); range_sel = 0; tach_per = 0;
    mon_en = 1; pwm_hi = 1;
    wait_done(2000, v);
    chk(v == 255, "R5", v, 255);
    idle_off(); tach_per = 600; mon_en = 1; pwm_hi = 1;
    wait_done(5000, v);
    chk(v == 255, "R5", v, 255);

    req = "R9"; idle_off(); tach_per = 40;
    mon_en = 1; pwm_hi = 1;
    wait_done(600, v);
    r0 = speed_rd; d0 = dones;
    repeat (30) @(negedge clk);
    mon_en = 0;
    repeat (200) @(negedge clk); #0.5;
    chk(dones == d0, "R9", dones - d0, 0);
    chk(speed_rd == r0, "R9", speed_rd, r0);

    req = "R5";
    for (int p = 500; p <= 516; p += 2) begin
      idle_off(); tach_per = p; mon_en = 1; pwm_hi = 1;
      wait_done(5000, v);
      chk(v >= 0, "R5", v, 250);
    end

    idle_off();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule